// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block derives the bit-rate enables for a serial port from the system clock. A 12-bit divisor, loaded through a byte-wide write port, sets the period of a programmable down-counter. Each time the counter reaches zero it emits a one-cycle base tick, and then it reloads. The base tick rate is therefore fclk/(divisor+1).

The receiver is given the undivided base tick and a per-bit sample count. The transmitter is given a bit enable that divides the base tick by 16 in normal asynchronous mode, by 8 in double-speed asynchronous mode, and by 2 in synchronous master mode. In synchronous master mode a square-wave clock output is also produced at the transmit bit rate.

The upper four divisor bits are staged. They take effect only together with the next low-byte write, so a reload never sees half of an old value and half of a new one.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor and the counter are zero, so `base_tick` is high on every clock cycle. With no mode input asserted, `tx_bit_en` pulses once every 16 cycles.
- R2: Once a divisor D is loaded, consecutive `base_tick` pulses are exactly D+1 clock cycles apart.
- R3: A low-byte write (`wr_en`=1, `wr_sel`=0) reloads the counter at once, whatever its current count. `base_tick` first goes high D clock edges after the edge that captures the write, or on the very next cycle when D is 0.
- R4: A high-byte write (`wr_en`=1, `wr_sel`=1) stores `wr_data[3:0]` in a staging register and leaves the active divisor unchanged. The next low-byte write loads the divisor {staged[3:0], `wr_data`[7:0]}.
- R5: `tx_bit_en` is high only in cycles where `base_tick` is high. It pulses once every 16 base ticks when `sync_mode`=0 and `dbl_speed`=0, and once every 8 base ticks when `sync_mode`=0 and `dbl_speed`=1.
- R6: When `sync_mode`=1, `tx_bit_en` pulses once every 2 base ticks and `dbl_speed` has no effect.
- R7: `rx_sample_en` equals `base_tick` on every cycle. `rx_states` reports 16, 8 or 2 under the same mode selection that R5 and R6 use.
- R8: While `sync_mode`=1, `mclk_out` inverts on the clock edge that ends every `base_tick` cycle and holds at all other edges. After any edge sampled with `sync_mode`=0, `mclk_out` is 0.
- R9: A change of the effective mode (sync, or double speed while asynchronous) suppresses `tx_bit_en` in that cycle and restarts the transmit prescaler. The first `tx_bit_en` after the change then lands on the Nth base tick after the change cycle, where N is the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_sel | input | 1 | 0 = low divisor byte, 1 = high divisor nibble |
| wr_data | input | 8 | Write data |
| sync_mode | input | 1 | 1 = synchronous master, 0 = asynchronous |
| dbl_speed | input | 1 | Double-speed select, asynchronous mode only |
| base_tick | output | 1 | One-cycle tick at fclk/(divisor+1) |
| tx_bit_en | output | 1 | Transmit bit-clock enable |
| rx_sample_en | output | 1 | Receiver oversampling enable |
| rx_states | output | 5 | Receiver samples per bit (16, 8 or 2) |
| mclk_out | output | 1 | Synchronous master clock output |

## Verification
A wrong count or divisor value shows at the ports within one base-tick period, as a gap between `base_tick` pulses that is not D+1. A staging or reload fault moves the first tick after a low-byte write away from the D-th edge. A prescaler that is not restarted, or that has the wrong ratio, shows at the first `tx_bit_en` after a mode change, at most 16 base ticks later. A fault in the master clock shows on the edge right after a tick, because `mclk_out` either fails to invert there or inverts on some other edge.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    RATE_ASYNC_NORM = 2'd0,
    RATE_ASYNC_DBL  = 2'd1,
    RATE_SYNC       = 2'd2
  } rate_mode_e;

  // Effective mode: the double-speed input only matters in asynchronous mode.
  function automatic rate_mode_e mode_of(input logic sync_sel, input logic dbl_sel);
    if (sync_sel)     return RATE_SYNC;
    else if (dbl_sel) return RATE_ASYNC_DBL;
    else              return RATE_ASYNC_NORM;
  endfunction

  // Base ticks per transmit bit, which is also the receiver's samples per bit.
  function automatic logic [4:0] ticks_per_bit(input rate_mode_e m);
    case (m)
      RATE_SYNC:      return 5'd2;
      RATE_ASYNC_DBL: return 5'd8;
      default:        return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/divisor_regs.sv
module divisor_regs #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q,
  output logic             load,
  output logic [DIV_W-1:0] load_val
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0] stage_hi;
  logic            hi_wr;

  assign hi_wr    = wr_en && wr_sel;
  assign load     = wr_en && !wr_sel;
  assign load_val = {stage_hi, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= '0;
      div_q    <= '0;
    end else begin
      if (hi_wr) stage_hi <= wr_data[HI_W-1:0];
      if (load)  div_q    <= load_val;
    end
  end

  // R4
  hi_write_no_div_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> $stable(div_q));
endmodule

// File: rtl/base_counter.sv
module base_counter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= div_q;
    else           cnt <= cnt - 1'b1;
  end

  // R3
  reload_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));

  // R2
  wrap_to_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt == $past(div_q));
endmodule

// File: rtl/tx_prescaler.sv
module tx_prescaler
  import baud_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  rate_mode_e mode,
  output logic       tx_en,
  output logic       restart
);
  rate_mode_e       mode_q;
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] last_cnt;
  logic             at_last;

  assign last_cnt = PRE_W'(ticks_per_bit(mode) - 5'd1);
  assign restart  = (mode != mode_q);
  assign at_last  = (pcnt == last_cnt);
  assign tx_en    = tick && at_last && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RATE_ASYNC_NORM;
      pcnt   <= '0;
    end else begin
      mode_q <= mode;
      if (restart)   pcnt <= '0;
      else if (tick) pcnt <= at_last ? '0 : pcnt + 1'b1;
    end
  end

  // R5
  tx_en_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> tick);

  // R5
  pcnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart || (pcnt <= last_cnt));

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pcnt == '0);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sync_mode,
  input  logic              dbl_speed,
  output logic              base_tick,
  output logic              tx_bit_en,
  output logic              rx_sample_en,
  output logic [4:0]        rx_states,
  output logic              mclk_out
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] load_val;
  logic             load;
  logic             mode_restart;
  rate_mode_e       eff_mode;

  assign eff_mode = mode_of(sync_mode, dbl_speed);

  divisor_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .div_q(div_q), .load(load), .load_val(load_val)
  );

  base_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .load(load),
    .load_val(load_val), .tick(base_tick)
  );

  tx_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .mode(eff_mode),
    .tx_en(tx_bit_en), .restart(mode_restart)
  );

  assign rx_sample_en = base_tick;
  assign rx_states    = ticks_per_bit(eff_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mclk_out <= 1'b0;
    else if (!sync_mode) mclk_out <= 1'b0;
    else if (base_tick)  mclk_out <= ~mclk_out;
  end

  // R8
  mclk_idle_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !mclk_out);

  // R8
  mclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && base_tick) |=> mclk_out != $past(mclk_out));

  // R7
  rx_states_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_states) == 1);

  // R6
  sync_ignores_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> rx_states == 5'd2);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sync_mode = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       base_tick, tx_bit_en, rx_sample_en, mclk_out;
  logic [4:0] rx_states;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sync_mode(sync_mode), .dbl_speed(dbl_speed),
    .base_tick(base_tick), .tx_bit_en(tx_bit_en), .rx_sample_en(rx_sample_en),
    .rx_states(rx_states), .mclk_out(mclk_out)
  );

  function automatic int exp_ratio(input logic s, input logic d);
    return s ? 2 : (d ? 8 : 16);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_byte(input logic sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  task automatic program_div(input int d);
    write_byte(1'b1, 8'((d >> 8) & 15));
    write_byte(1'b0, 8'(d & 255));
  endtask

  task automatic tick_gap(output int gap);
    int n = 0;
    while (!base_tick && n < 10000) begin step(); n++; end
    gap = 0;
    do begin step(); gap++; end while (!base_tick && gap < 10000);
  endtask

  task automatic tx_gap(output int gap);
    int n = 0;
    while (!tx_bit_en && n < 100000) begin step(); n++; end
    gap = 0;
    do begin step(); gap++; end while (!tx_bit_en && gap < 100000);
  endtask

  task automatic t_reset();
    int ticks = 0, txs = 0, mbad = 0;
    for (int i = 0; i < 32; i++) begin
      if (base_tick) ticks++;
      if (tx_bit_en) txs++;
      if (mclk_out) mbad++;
      step();
    end
    check("R1 base_tick every cycle", ticks, 32);
    check("R1 tx_bit_en per 32 cycles", txs, 2);
    check("R8 mclk_out low after reset", mbad, 0);
    check("R7 rx_states after reset", rx_states, 16);
  endtask

  task automatic t_period(input int d);
    int g;
    program_div(d);
    tick_gap(g);
    check($sformatf("R2 gap for divisor %0d", d), g, d + 1);
  endtask

  task automatic t_reload();
    int k = 0;
    program_div(200);
    repeat (50) step();
    write_byte(1'b0, 8'd10);
    check("R3 no tick right after write", base_tick, 0);
    while (!base_tick && k < 1000) begin step(); k++; end
    check("R3 edges to first tick after reload", k, 10);
    program_div(0);
    check("R3 tick right after divisor 0 load", base_tick, 1);
  endtask

  task automatic t_staging();
    int g;
    program_div(5);
    write_byte(1'b1, 8'h01);
    tick_gap(g);
    check("R4 high write alone keeps period", g, 6);
    write_byte(1'b0, 8'd3);
    tick_gap(g);
    check("R4 staged high nibble applied", g, 256 + 3 + 1);
  endtask

  task automatic t_ratios();
    int g, bad = 0, rxbad = 0;
    program_div(2);
    for (int m = 0; m < 4; m++) begin
      sync_mode = m[1]; dbl_speed = m[0];
      step();
      tx_gap(g);
      if (m[1]) check("R6 sync tx gap", g, 3 * 2);
      else      check("R5 async tx gap", g, 3 * exp_ratio(1'b0, m[0]));
      check("R7 rx_states for mode", rx_states, exp_ratio(m[1], m[0]));
      for (int i = 0; i < 60; i++) begin
        if (tx_bit_en && !base_tick) bad++;
        if (rx_sample_en != base_tick) rxbad++;
        step();
      end
      check("R5 tx_bit_en only with base_tick", bad, 0);
      check("R7 rx_sample_en tracks base_tick", rxbad, 0);
    end
    sync_mode = 0; dbl_speed = 0;
    step();
  endtask

  task automatic t_mclk();
    int bad = 0, hi = 0;
    logic prev_m, prev_t;
    program_div(1);
    sync_mode = 1; dbl_speed = 0;
    step();
    prev_m = mclk_out; prev_t = base_tick;
    for (int i = 0; i < 40; i++) begin
      step();
      if ((mclk_out != prev_m) != prev_t) bad++;
      if (mclk_out) hi++;
      prev_m = mclk_out; prev_t = base_tick;
    end
    check("R8 mclk toggles only after ticks", bad, 0);
    check("R8 mclk square wave high half", hi, 20);
    sync_mode = 0;
    step();
    check("R8 mclk low in async", mclk_out, 0);
  endtask

  task automatic t_restart();
    int ticks = 0, n = 0;
    program_div(2);
    sync_mode = 0; dbl_speed = 0;
    repeat (20) step();
    dbl_speed = 1;
    #0;
    check("R9 tx_bit_en suppressed in change cycle", tx_bit_en, 0);
    step();
    while (n < 1000) begin
      if (base_tick) ticks++;
      if (tx_bit_en) break;
      step(); n++;
    end
    check("R9 first tx_bit_en after change", ticks, 8);
    sync_mode = 1;
    #0;
    step();
    ticks = 0; n = 0;
    while (n < 1000) begin
      if (base_tick) ticks++;
      if (tx_bit_en) break;
      step(); n++;
    end
    check("R9 first tx_bit_en after sync switch", ticks, 2);
    sync_mode = 0; dbl_speed = 0;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period(0);
    t_period(7);
    t_period(100);
    t_reload();
    t_staging();
    t_ratios();
    t_mclk();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule